// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits beside a small processor core and decides which interrupt the core takes next. Eight request inputs, one per vector slot, set sticky pending latches. The core marks the final clock of every instruction with a strobe. On that clock edge, and only on that edge, the controller compares the pending latches when the global enable is set and no dispatch is under way. It picks the lowest-numbered pending slot and starts a dispatch. Slot 0 holds the reset entry and has the highest priority. Slot 1 is the short timer tick, slot 2 the long timer tick, slots 3 and 4 the two endpoint events, slot 6 the general-purpose pin event and slot 7 the wake-up event. Slot 5 is reserved and is never dispatched.

A dispatch has two phases that the core follows. A 10-cycle call phase comes first, during which the core must push its program counter and its carry and zero flags. A 5-cycle jump phase follows, at the end of which the service routine starts. The vector address is the slot number times two, because each slot holds a two-byte jump. Taking an interrupt clears the global enable. A return-from-interrupt sets the enable again, and separate set and clear inputs give software direct control of it.

FSM states: `ST_IDLE` (waiting for a boundary), `ST_CALL` (context save, 10 cycles) and `ST_JUMP` (vector fetch, 5 cycles). Transitions: `ST_IDLE -> ST_CALL` on a take, `ST_CALL -> ST_JUMP` on the last call cycle, `ST_JUMP -> ST_IDLE` on the last jump cycle.

Top module: `intvec_ctrl`

## Requirements
- R1: A one-cycle high on `req_i[n]` sets pending bit n. `pending_o[n]` shows it from the next cycle, and it stays set until that slot is dispatched.
- R2: Slot 5 is reserved. A request on `req_i[5]` leaves `pending_o[5]` at 0 and never starts a dispatch.
- R3: A dispatch starts only at a rising edge where `instr_last_i` is high, the global enable `gie_o` is high, the controller is idle and some eligible slot is pending. With the enable low or no boundary strobe, nothing is taken.
- R4: When several slots are pending, the lowest slot number is dispatched first.
- R5: `vec_o` equals 2 × slot number (0x00, 0x02 … 0x0E) from the first dispatch cycle and holds that value for the whole dispatch.
- R6: `ack_o` is high for exactly the first cycle after the take edge. `save_ctx_o` is high for the 10 call-phase cycles.
- R7: `busy_o` is high for exactly 15 consecutive cycles per dispatch: 10 call cycles followed by 5 jump cycles.
- R8: The take edge clears `gie_o` and the chosen slot's pending bit. Other pending bits are kept.
- R9: A high on `reti_i` or `gie_set_i` sets `gie_o`, and `gie_clr_i` alone clears it. A take on the same edge overrides a set, so `gie_o` ends at 0.
- R10: Requests arriving during a dispatch are latched. `instr_last_i` during a dispatch is ignored, and the latched requests are judged at the first boundary after the dispatch ends.
- R11: After reset, `pending_o`, `gie_o`, `busy_o`, `ack_o`, `save_ctx_o` and `vec_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Per-slot request pulses, bit n for slot n |
| instr_last_i | input | 1 | High on the last clock of the current instruction |
| gie_set_i | input | 1 | Sets the global interrupt enable |
| gie_clr_i | input | 1 | Clears the global interrupt enable |
| reti_i | input | 1 | Return-from-interrupt, sets the global enable |
| vec_o | output | 8 | Vector address of the dispatched slot |
| ack_o | output | 1 | One-cycle acknowledge at dispatch start |
| save_ctx_o | output | 1 | High while PC and flags must be saved |
| busy_o | output | 1 | High during the whole dispatch window |
| gie_o | output | 1 | Global interrupt enable |
| pending_o | output | 8 | Pending request latches |

## Verification
The assertions check several properties on every cycle. Every dispatch window lasts exactly 15 cycles, and a dispatch begins only after a boundary strobe with the enable set. The acknowledge is a single-cycle pulse, the vector is stable and never points at the reserved slot during a dispatch, and a return always leaves the enable set unless a take consumed it. Other behaviour shows only in the bench scenarios. These cover which slot wins among several pending ones, that late requests survive a dispatch and are served at the next boundary, that a take overrides a simultaneous return, and that the chosen latch alone is cleared.

// File: rtl/intvec_pkg.sv
`timescale 1ns/1ps
package intvec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALL = 2'd1,
        ST_JUMP = 2'd2
    } disp_state_t;
endpackage

// File: rtl/intvec_latch.sv
`timescale 1ns/1ps
module intvec_latch #(
    parameter int N_SLOTS  = 8,
    parameter int RSV_SLOT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SLOTS-1:0] req_i,
    input  logic               take_i,
    input  logic [N_SLOTS-1:0] clr_i,
    output logic [N_SLOTS-1:0] pend_o
);
    localparam logic [N_SLOTS-1:0] ELIG = ~(N_SLOTS'(1) << RSV_SLOT);

    logic [N_SLOTS-1:0] pend_q;
    logic [N_SLOTS-1:0] clr_mask;

    assign clr_mask = take_i ? clr_i : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            // new arrivals are kept even on the take edge; only the chosen bit drops
            pend_q <= ((pend_q & ~clr_mask) | req_i) & ELIG;
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/intvec_prio.sv
`timescale 1ns/1ps
module intvec_prio #(
    parameter int N_SLOTS = 8,
    localparam int IDX_W  = $clog2(N_SLOTS)
) (
    input  logic [N_SLOTS-1:0] pend_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [N_SLOTS-1:0] onehot_o
);
    logic [N_SLOTS-1:0] lower_set;

    // lower_set[i]: some slot below i is pending
    assign lower_set[0] = 1'b0;
    for (genvar g = 1; g < N_SLOTS; g++) begin : g_chain
        assign lower_set[g] = lower_set[g-1] | pend_i[g-1];
    end

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_win
        assign onehot_o[g] = pend_i[g] & ~lower_set[g];
    end

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (onehot_o[i]) idx_o = IDX_W'(i);
        end
    end

    assign any_o = |pend_i;
endmodule

// File: rtl/intvec_seq.sv
`timescale 1ns/1ps
module intvec_seq
    import intvec_pkg::*;
#(
    parameter int CALL_CYC = 10,
    parameter int JUMP_CYC = 5,
    localparam int MAX_CYC = (CALL_CYC > JUMP_CYC) ? CALL_CYC : JUMP_CYC,
    localparam int CNT_W   = $clog2(MAX_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic ack_o,
    output logic call_o
);
    localparam logic [CNT_W-1:0] CALL_LAST = CNT_W'(CALL_CYC - 1);
    localparam logic [CNT_W-1:0] JUMP_LAST = CNT_W'(JUMP_CYC - 1);

    disp_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)            state_d = ST_CALL;
            ST_CALL: if (cnt_q == CALL_LAST) state_d = ST_JUMP;
            ST_JUMP: if (cnt_q == JUMP_LAST) state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
        end
    end

    always_comb begin
        busy_o = 1'b0;
        ack_o  = 1'b0;
        call_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_CALL: begin
                busy_o = 1'b1;
                call_o = 1'b1;
                ack_o  = (cnt_q == '0);
            end
            ST_JUMP: busy_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/intvec_ctrl.sv
`timescale 1ns/1ps
module intvec_ctrl #(
    parameter int N_SLOTS  = 8,
    parameter int RSV_SLOT = 5,
    parameter int CALL_CYC = 10,
    parameter int JUMP_CYC = 5,
    parameter int VEC_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SLOTS-1:0] req_i,
    input  logic               instr_last_i,
    input  logic               gie_set_i,
    input  logic               gie_clr_i,
    input  logic               reti_i,
    output logic [VEC_W-1:0]   vec_o,
    output logic               ack_o,
    output logic               save_ctx_o,
    output logic               busy_o,
    output logic               gie_o,
    output logic [N_SLOTS-1:0] pending_o
);
    localparam int IDX_W = $clog2(N_SLOTS);

    logic [N_SLOTS-1:0] pend, win_onehot;
    logic [IDX_W-1:0]   win_idx;
    logic               any_pend, take, gie_q, busy;
    logic [VEC_W-1:0]   vec_q;

    intvec_latch #(.N_SLOTS(N_SLOTS), .RSV_SLOT(RSV_SLOT)) u_latch (
        .clk(clk), .rst_n(rst_n), .req_i(req_i),
        .take_i(take), .clr_i(win_onehot), .pend_o(pend)
    );

    intvec_prio #(.N_SLOTS(N_SLOTS)) u_prio (
        .pend_i(pend), .any_o(any_pend), .idx_o(win_idx), .onehot_o(win_onehot)
    );

    intvec_seq #(.CALL_CYC(CALL_CYC), .JUMP_CYC(JUMP_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(take),
        .busy_o(busy), .ack_o(ack_o), .call_o(save_ctx_o)
    );

    assign take = instr_last_i & gie_q & any_pend & ~busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q <= 1'b0;
            vec_q <= '0;
        end else begin
            if (take)                        gie_q <= 1'b0;
            else if (reti_i || gie_set_i)    gie_q <= 1'b1;
            else if (gie_clr_i)              gie_q <= 1'b0;
            if (take) vec_q <= VEC_W'({win_idx, 1'b0});
        end
    end

    assign vec_o     = vec_q;
    assign busy_o    = busy;
    assign gie_o     = gie_q;
    assign pending_o = pend;
endmodule

// File: rtl/intvec_chk.sv
`timescale 1ns/1ps
module intvec_chk #(
    parameter int N_SLOTS  = 8,
    parameter int RSV_SLOT = 5,
    parameter int CALL_CYC = 10,
    parameter int JUMP_CYC = 5,
    parameter int VEC_W    = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               instr_last_i,
    input logic               reti_i,
    input logic [VEC_W-1:0]   vec_o,
    input logic               ack_o,
    input logic               busy_o,
    input logic               gie_o,
    input logic [N_SLOTS-1:0] pending_o
);
    localparam int TOTAL = CALL_CYC + JUMP_CYC;
    localparam int WC_W  = $clog2(TOTAL + 2);
    localparam logic [VEC_W-1:0] RSV_VEC = VEC_W'(2 * RSV_SLOT);

    logic [WC_W-1:0] win_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)      win_cnt <= '0;
        else if (busy_o) win_cnt <= win_cnt + 1'b1;
        else             win_cnt <= '0;
    end

    p_window_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> win_cnt == WC_W'(TOTAL));

    p_boundary_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(instr_last_i) && $past(gie_o)));

    p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    p_ack_gie_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !gie_o);

    p_vec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ack_o) |-> $stable(vec_o));

    p_no_rsv_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> vec_o != RSV_VEC);

    p_no_rsv_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_o[RSV_SLOT]);

    p_reti_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i |=> (gie_o || ack_o));
endmodule

bind intvec_ctrl intvec_chk #(
    .N_SLOTS(N_SLOTS), .RSV_SLOT(RSV_SLOT), .CALL_CYC(CALL_CYC),
    .JUMP_CYC(JUMP_CYC), .VEC_W(VEC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .instr_last_i(instr_last_i), .reti_i(reti_i),
    .vec_o(vec_o), .ack_o(ack_o), .busy_o(busy_o), .gie_o(gie_o),
    .pending_o(pending_o)
);

// File: tb/sim_intvec_ctrl.sv
`timescale 1ns/1ps
module sim_intvec_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = '0;
    logic       instr_last = 1'b0, gie_set = 1'b0, gie_clr = 1'b0, reti = 1'b0;
    logic [7:0] vec_o, pending_o;
    logic       ack_o, save_ctx_o, busy_o, gie_o;

    int tests = 0, fails = 0;
    logic [7:0] expq[$];

    always #2.5 clk = ~clk;

    intvec_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .instr_last_i(instr_last),
        .gie_set_i(gie_set), .gie_clr_i(gie_clr), .reti_i(reti),
        .vec_o(vec_o), .ack_o(ack_o), .save_ctx_o(save_ctx_o),
        .busy_o(busy_o), .gie_o(gie_o), .pending_o(pending_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected vectors on ack, measures each dispatch window
    int  bcnt = 0, ccnt = 0;
    bit  prev_busy = 0, vchg = 0;
    logic [7:0] run_vec = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ack_o) begin
                if (expq.size() == 0) chk(0, "R3 unexpected dispatch", {24'd0, vec_o}, 0);
                else begin
                    logic [7:0] e;
                    e = expq.pop_front();
                    chk(vec_o == e, "R4/R5 vector", {24'd0, vec_o}, {24'd0, e});
                end
                run_vec = vec_o;
            end
            if (busy_o) begin
                bcnt++;
                if (save_ctx_o) ccnt++;
                if (vec_o != run_vec) vchg = 1;
            end
            if (prev_busy && !busy_o) begin
                chk(bcnt == 15, "R7 busy length", bcnt, 15);
                chk(ccnt == 10, "R6 save_ctx length", ccnt, 10);
                chk(!vchg, "R5 vector held", vchg, 0);
                bcnt = 0; ccnt = 0; vchg = 0;
            end
            prev_busy = busy_o;
        end
    end

    task automatic pulse_req(input logic [7:0] m);
        @(negedge clk); req = m;
        @(negedge clk); req = '0;
    endtask

    task automatic pulse_set();
        @(negedge clk); gie_set = 1;
        @(negedge clk); gie_set = 0;
    endtask

    task automatic boundary(input bit exp_take, input logic [7:0] ev, input string tag);
        @(negedge clk); instr_last = 1;
        if (exp_take) expq.push_back(ev);
        @(negedge clk); instr_last = 0;
        chk(busy_o == exp_take, tag, busy_o, exp_take);
        if (exp_take) begin
            repeat (15) @(negedge clk);
            chk(!busy_o, "R7 dispatch over", busy_o, 0);
        end
    endtask

    initial begin
        #(200000 * 5);
        chk(0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk({pending_o, gie_o, busy_o, ack_o, save_ctx_o, vec_o} == '0, "R11 reset state",
            {pending_o, gie_o, busy_o, ack_o, save_ctx_o, vec_o}, 0);

        // R1 latch, R3 no take with enable low
        pulse_req(8'h08);
        chk(pending_o == 8'h08, "R1 pending set", pending_o, 8'h08);
        boundary(0, 8'h00, "R3 enable low no take");
        chk(pending_o == 8'h08, "R1 pending kept", pending_o, 8'h08);

        // R3 enable high but no boundary strobe
        pulse_set();
        repeat (4) @(negedge clk);
        chk(!busy_o, "R3 no strobe no take", busy_o, 0);

        // R2 reserved ignored, R4 priority 3 over 6
        pulse_req(8'h60);
        chk(pending_o == 8'h48, "R2 reserved not latched", pending_o, 8'h48);

        // R10 dispatch with activity in flight
        @(negedge clk); instr_last = 1; expq.push_back(8'h06);
        @(negedge clk); instr_last = 0; req = 8'h02;
        chk(!gie_o, "R8 enable cleared", gie_o, 0);
        @(negedge clk); req = '0; instr_last = 1;
        @(negedge clk); instr_last = 0;
        chk(pending_o == 8'h42, "R8/R10 chosen cleared, others kept", pending_o, 8'h42);
        repeat (13) @(negedge clk);
        chk(!busy_o, "R10 strobe in dispatch ignored", busy_o, 0);
        chk(expq.size() == 0, "R10 single dispatch", expq.size(), 0);

        pulse_set();
        boundary(1, 8'h02, "R10 late request served");
        chk(pending_o == 8'h40, "R8 pending after take", pending_o, 8'h40);
        @(negedge clk); reti = 1;
        @(negedge clk); reti = 0;
        chk(gie_o, "R9 reti sets enable", gie_o, 1);
        boundary(1, 8'h0C, "R4 slot 6 dispatch");
        chk(pending_o == 8'h00, "R1 all served", pending_o, 0);

        // R2 reserved alone never dispatched
        pulse_set();
        pulse_req(8'h20);
        chk(pending_o == 8'h00, "R2 pending stays 0", pending_o, 0);
        boundary(0, 8'h00, "R2 reserved never taken");

        // R5 extreme vectors, R4 slot 0 first
        pulse_req(8'h81);
        boundary(1, 8'h00, "R5 slot 0");
        pulse_set();
        boundary(1, 8'h0E, "R5 slot 7");

        // R9 set then clear
        pulse_set();
        @(negedge clk); gie_clr = 1;
        @(negedge clk); gie_clr = 0;
        chk(!gie_o, "R9 clear", gie_o, 0);
        pulse_req(8'h04);
        boundary(0, 8'h00, "R3 cleared enable blocks");

        // R9 take overrides simultaneous reti
        pulse_set();
        @(negedge clk); instr_last = 1; reti = 1; expq.push_back(8'h04);
        @(negedge clk); instr_last = 0; reti = 0;
        chk(!gie_o, "R9 take wins over reti", gie_o, 0);
        repeat (15) @(negedge clk);
        chk(!gie_o, "R9 enable still off", gie_o, 0);

        chk(expq.size() == 0, "R4 all expected dispatches seen", expq.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule